// File: doc/BRIEF.md
# Dual-Channel Sample Output Multiplexer

This block takes a pair of sample words, one for the in-phase channel and one for the quadrature channel, that arrive together on every clock. It registers them and presents them on two output buses along with a phase flag. A mode input chooses how the buses are used. In parallel mode each channel drives its own bus on every clock. In interleaved mode the two channels take turns on the I bus, and the Q bus is held at zero.

A format input chooses how each output word is coded. Incoming samples are offset binary. Two's complement is produced by inverting the most significant bit. The format input may change at any time, so it passes through a two-stage synchronizer before it is used.

In interleaved mode each sample pair takes two output slots, with I first and Q second. A pair is captured only on the slot that starts a new pair. This keeps the I and Q words of one pair together on the bus.

Top module: `iq_out_mux`

## Requirements
- R1: While `rstN` is low, and after the first clock edge with it low, `busI`, `busQ` and `phaseFlag` are all zero.
- R2: With `busSel` high (parallel mode), inputs sampled at clock edge k appear on `busI` and `busQ` after edge k+1.
- R3: With `busSel` low (interleaved mode), a pair is captured on the first edge after reset and then on every second edge. Inputs present at the edges in between are ignored. The captured I word is on `busI` after the next edge, and the captured Q word after the edge after that.
- R4: In interleaved mode every bit of `busQ` is zero.
- R5: In interleaved mode `phaseFlag` is 1 while an I word is on `busI` and 0 while a Q word is on it.
- R6: In parallel mode `phaseFlag` is 1 with every registered output word.
- R7: With the synchronized format low, output words equal the input bits unchanged (offset binary). Bit 0 is the LSB.
- R8: With the synchronized format high, the output is two's complement: bit SAMPLE_W-1 is inverted and all other bits pass through unchanged.
- R9: A change on `fmtSel` reaches the outputs on the third clock edge after the change and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleI | input | SAMPLE_W | In-phase sample, offset binary |
| sampleQ | input | SAMPLE_W | Quadrature sample, offset binary |
| busSel | input | 1 | 1 = parallel mode, 0 = interleaved mode |
| fmtSel | input | 1 | 0 = offset binary, 1 = two's complement; asynchronous to `clk` |
| busI | output | SAMPLE_W | I output bus; in interleaved mode it carries both channels |
| busQ | output | SAMPLE_W | Q output bus; zero in interleaved mode |
| phaseFlag | output | 1 | Marks the I word in interleaved mode; high in parallel mode |

## Verification
The hardest case to reach from the ports is the pairing in interleaved mode. A fault that captures on the wrong slot, or that mixes the I word of one pair with the Q word of the next, still produces plausible words. To expose it, the stimulus starts from reset so that the slot phase is known. It then holds a distinct marker pair only on the capture edges and drives junk values on the edges in between. Any misaligned capture puts a junk word, or a word from the wrong pair, on `busI`.

// File: rtl/iq_out_pkg.sv
package iq_out_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic capture;   // load the sample pair register
    logic selQ;      // output slot carries the Q word
    logic parallel;  // parallel mode is selected
    logic twosComp;  // synchronized two's complement select
  } iqStrobe_t;
endpackage

// File: rtl/iq_out_ctrl.sv
module iq_out_ctrl
  import iq_out_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busSel,
  input  logic      fmtSel,
  output iqStrobe_t strobe
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] fmtPipe;
  logic slotQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtPipe <= '0;
      slotQ   <= 1'b0;
    end else begin
      fmtPipe <= {fmtPipe[SYNC_STAGES-2:0], fmtSel};
      slotQ   <= busSel ? 1'b0 : ~slotQ;
    end
  end

  always_comb begin
    strobe.parallel = busSel;
    strobe.capture  = busSel | ~slotQ;
    strobe.selQ     = ~busSel & ~slotQ;
    strobe.twosComp = fmtPipe[SYNC_STAGES-1];
  end

  AST_CAPTURE_ALTERNATE: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel && strobe.capture) |=> (busSel || !strobe.capture)); // R3
endmodule

// File: rtl/iq_out_dp.sv
module iq_out_dp
  import iq_out_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  iqStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0] sampleI,
  input  logic [SAMPLE_W-1:0] sampleQ,
  output logic [SAMPLE_W-1:0] busI,
  output logic [SAMPLE_W-1:0] busQ,
  output logic                phaseFlag
);
  localparam int MSB = SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] pairI, pairQ;
  logic [SAMPLE_W-1:0] slotWord, codedI, codedQ;

  function automatic logic [SAMPLE_W-1:0] recode(input logic [SAMPLE_W-1:0] w, input logic twos);
    recode = w;
    recode[MSB] = w[MSB] ^ twos;
  endfunction

  always_comb begin
    slotWord = strobe.selQ ? pairQ : pairI;
    codedI   = recode(slotWord, strobe.twosComp);
    codedQ   = strobe.parallel ? recode(pairQ, strobe.twosComp) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairI     <= '0;
      pairQ     <= '0;
      busI      <= '0;
      busQ      <= '0;
      phaseFlag <= 1'b0;
    end else begin
      if (strobe.capture) begin
        pairI <= sampleI;
        pairQ <= sampleQ;
      end
      busI      <= codedI;
      busQ      <= codedQ;
      phaseFlag <= strobe.parallel | ~strobe.selQ;
    end
  end

  AST_QBUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.parallel |=> busQ == '0); // R4
  AST_FLAG_PARALLEL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.parallel |=> phaseFlag); // R6
  AST_SLOT_PAIRING: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.parallel && strobe.capture) |-> strobe.selQ); // R5
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.parallel && !strobe.twosComp) |=> busI == $past(pairI)); // R7
  AST_TWOS_MSB: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.parallel && strobe.twosComp) |=> busQ[MSB] == ~$past(pairQ[MSB])); // R8
endmodule

// File: rtl/iq_out_mux.sv
module iq_out_mux
  import iq_out_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleI,
  input  logic [SAMPLE_W-1:0] sampleQ,
  input  logic                busSel,
  input  logic                fmtSel,
  output logic [SAMPLE_W-1:0] busI,
  output logic [SAMPLE_W-1:0] busQ,
  output logic                phaseFlag
);
  iqStrobe_t strobe;

  iq_out_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busSel (busSel),
    .fmtSel (fmtSel),
    .strobe (strobe)
  );

  iq_out_dp #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sampleI   (sampleI),
    .sampleQ   (sampleQ),
    .busI      (busI),
    .busQ      (busQ),
    .phaseFlag (phaseFlag)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (busI == '0 && busQ == '0 && !phaseFlag)); // R1
endmodule

// File: tb/test_iq_out_mux.sv
module test_iq_out_mux;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] sampleI = '0, sampleQ = '0;
  logic busSel = 1'b1, fmtSel = 1'b0;
  logic [W-1:0] busI, busQ;
  logic phaseFlag;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  iq_out_mux #(.SAMPLE_W(W)) i_iq_out_mux (
    .clk(clk), .rstN(rstN), .sampleI(sampleI), .sampleQ(sampleQ),
    .busSel(busSel), .fmtSel(fmtSel), .busI(busI), .busQ(busQ),
    .phaseFlag(phaseFlag)
  );

  function automatic logic [W-1:0] twos(input logic [W-1:0] w);
    return {~w[W-1], w[W-2:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // advance one edge, return at the following falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic mode, input logic fmt);
    @(negedge clk);
    rstN = 1'b0; busSel = mode; fmtSel = fmt;
    step(4);
  endtask

  task automatic testReset();
    sampleI = 10'h3FF; sampleQ = 10'h3FF; busSel = 1'b1;
    doReset(1'b1, 1'b0);
    chk("R1 busI", busI, 0);
    chk("R1 busQ", busQ, 0);
    chk("R1 phaseFlag", phaseFlag, 0);
  endtask

  task automatic testParallel();
    doReset(1'b1, 1'b0);
    sampleI = 10'h123; sampleQ = 10'h2A5;
    rstN = 1'b1;
    step(1);                       // edge k captures
    chk("R6 flag with word", phaseFlag, 1);
    sampleI = 10'h001; sampleQ = 10'h3FE;
    step(1);                       // edge k+1 presents first pair
    chk("R2 busI", busI, 10'h123);
    chk("R2 busQ", busQ, 10'h2A5);
    chk("R7 offset pass", busQ, 10'h2A5);
    step(1);
    chk("R2 busI next", busI, 10'h001);
    chk("R7 LSB kept busQ", busQ, 10'h3FE);
    chk("R6 flag held", phaseFlag, 1);
  endtask

  task automatic testInterleave();
    doReset(1'b0, 1'b0);
    sampleI = 10'h111; sampleQ = 10'h222;
    rstN = 1'b1;
    step(1);                       // E1 captures pair A
    sampleI = 10'h3C3; sampleQ = 10'h0F0;   // junk, must be ignored
    step(1);                       // E2
    chk("R3 I word A", busI, 10'h111);
    chk("R5 flag I", phaseFlag, 1);
    chk("R4 busQ zero", busQ, 0);
    sampleI = 10'h155; sampleQ = 10'h2AA;   // pair B
    step(1);                       // E3 captures B, shows Q_A
    chk("R3 Q word A", busI, 10'h222);
    chk("R5 flag Q", phaseFlag, 0);
    sampleI = 10'h000; sampleQ = 10'h3FF;   // junk
    step(1);                       // E4
    chk("R3 I word B", busI, 10'h155);
    chk("R4 busQ zero B", busQ, 0);
    step(1);                       // E5
    chk("R3 Q word B", busI, 10'h2AA);
    chk("R5 flag Q B", phaseFlag, 0);
  endtask

  task automatic testTwos();
    doReset(1'b1, 1'b1);
    rstN = 1'b1;
    step(4);                       // synchronizer settled
    sampleI = 10'h200; sampleQ = 10'h000;
    step(2);
    chk("R8 midscale I", busI, twos(10'h200));
    chk("R8 zero Q", busQ, 10'h200);
    sampleI = 10'h3FF; sampleQ = 10'h0A5;
    step(2);
    chk("R8 full I", busI, 10'h1FF);
    chk("R8 low bits Q", busQ, twos(10'h0A5));
  endtask

  task automatic testFmtSync();
    doReset(1'b1, 1'b0);
    sampleI = 10'h0C3; sampleQ = 10'h1E1;
    rstN = 1'b1;
    step(4);
    chk("R9 before change", busI, 10'h0C3);
    fmtSel = 1'b1;
    step(2);
    chk("R9 not yet after two edges", busI, 10'h0C3);
    step(1);
    chk("R9 applied third edge", busI, 10'h2C3);
    chk("R9 applied busQ", busQ, 10'h3E1);
    fmtSel = 1'b0;
    step(3);
    chk("R9 back to offset", busQ, 10'h1E1);
  endtask

  initial begin
    testReset();
    testParallel();
    testInterleave();
    testTwos();
    testFmtSync();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule